// File: doc/BRIEF.md
# Load Queue with Store-Ordering Check

This block keeps the in-flight loads of an out-of-order core in a circular array, ordered by program age. The front end places each new load at the tail; the load receives the slot number it landed in and keeps a snapshot of the store-queue tail, or an all-ones marker if the store queue was empty. When a load executes, its effective address is written into its slot. When a store executes, the store gives the load-queue index it noted at its own allocation and its address. The block then searches every load from that index up to the present tail for one that touches the same 256-byte block, which means the load ran too early.

The first such load is latched as the pending violator. The store sees a fault in that same cycle. A later read of the violator returns it and clears it, and no new search is made while one is still pending. Commit releases entries from the head in age order, and a squash releases entries from the newest end. An occupancy count and full and empty flags report the fill state. The array has one more slot than the usable depth, so the head and tail pointers can tell a full queue from an empty one.

Top module: `load_queue_ordchk`

## Requirements
- R1: After reset the count is 0, `empty` is 1, `full` is 0, `viol_valid` is 0 and `alloc_idx` is 0.
- R2: An allocation takes the slot shown on `alloc_idx`, which is the tail. The tail then advances modulo DEPTH+1. When the count equals DEPTH, `full` is 1. An allocation while full is ignored: count and tail stay the same, and `alloc_err` is 1 in the following cycle.
- R3: Each load stores a store-queue reference. It is `{0, alloc_sq_tail}` when `alloc_sq_empty` is 0, and all ones (SQ_W+1 bits) when `alloc_sq_empty` is 1. For the violator, this reference is returned on `viol_sq_ref`.
- R4: `exec_valid` writes an address into an occupied slot and marks the slot executed. A freshly allocated load counts as not executed and never matches, even if its slot held an executed load before.
- R5: A store check covers only the slots from `chk_lq_idx` up to, and not including, the current tail. An index equal to the tail gives an empty window.
- R6: Addresses match when they are equal after the low BLK_SHIFT (8) bits are dropped. The dropped bits have no effect on the result.
- R7: The first matching load in the window, counted from `chk_lq_idx`, raises `chk_fault` combinationally. In the next cycle that load appears as the violator: its slot on `viol_idx` and its sequence number on `viol_seq`.
- R8: While a violator is pending, store checks raise no fault and leave the violator unchanged. Pulsing `viol_rd` clears `viol_valid` in the next cycle.
- R9: Commit frees head entries one after another while the queue is non-empty and the head's sequence number is less than or equal to `commit_seq`. It stops at the first younger entry.
- R10: Squash frees entries from the newest end while their sequence number is greater than `squash_seq`. The tail moves back over each freed entry. In a squash cycle, commit and allocation are ignored.
- R11: `count`, `full` and `empty` show the state after each operation, one cycle after the edge on which the operation is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a load at the tail |
| alloc_seq | input | SEQ_W | Sequence number of the new load |
| alloc_sq_tail | input | SQ_W | Store-queue tail at allocation |
| alloc_sq_empty | input | 1 | Store queue is empty at allocation |
| alloc_idx | output | IDX_W | Slot the next allocation takes |
| alloc_err | output | 1 | The previous cycle attempted an allocation while full |
| exec_valid | input | 1 | Executed-load address update |
| exec_idx | input | IDX_W | Slot of the executed load |
| exec_addr | input | ADDR_W | Effective address of the executed load |
| chk_valid | input | 1 | Store check request |
| chk_lq_idx | input | IDX_W | Load index the store noted at its allocation |
| chk_addr | input | ADDR_W | Store address |
| chk_fault | output | 1 | Ordering violation found by this check |
| commit_valid | input | 1 | Commit request |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Entries younger than this are removed |
| viol_rd | input | 1 | Read and clear the pending violator |
| viol_valid | output | 1 | A violator is pending |
| viol_idx | output | IDX_W | Slot of the violating load |
| viol_seq | output | SEQ_W | Sequence number of the violating load |
| viol_sq_ref | output | SQ_W+1 | Store-queue reference of the violating load |
| count | output | CNT_W | Number of occupied entries |
| full | output | 1 | Queue holds DEPTH loads |
| empty | output | 1 | Queue holds no load |

## Verification
The search is swept over every start index from the head to the tail inclusive, against store addresses that include the first and last byte of a block and an address one block off. This separates an off-by-one window, a wrong shift and a missing tail bound. Two executed loads in one block tell oldest-first selection apart from newest-first. A load placed in a slot that previously held an executed load shows whether the executed flag is cleared on allocation. Overflow, a commit that stops at a younger head, a squash issued together with commit and allocate, and a squash of everything check the pointer arithmetic across the wrap point.

// File: rtl/lq_pkg.sv
package lq_pkg;
  // forward distance on the ring
  function automatic int unsigned ring_add(int unsigned a, int unsigned b, int unsigned slots);
    return (a + b) % slots;
  endfunction
  // backward distance on the ring (b < slots)
  function automatic int unsigned ring_sub(int unsigned a, int unsigned b, int unsigned slots);
    return (a + slots - b) % slots;
  endfunction
endpackage

// File: rtl/lq_entry_store.sv
module lq_entry_store #(
  parameter int SLOTS  = 5,
  parameter int IDX_W  = 3,
  parameter int SEQ_W  = 16,
  parameter int REF_W  = 4,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_we,
  input  logic [IDX_W-1:0]  alloc_slot,
  input  logic [SEQ_W-1:0]  alloc_seq,
  input  logic [REF_W-1:0]  alloc_ref,
  input  logic              exec_we,
  input  logic [IDX_W-1:0]  exec_slot,
  input  logic [ADDR_W-1:0] exec_addr,
  output logic [SEQ_W-1:0]  seq_q  [SLOTS],
  output logic [REF_W-1:0]  ref_q  [SLOTS],
  output logic              aval_q [SLOTS],
  output logic [ADDR_W-1:0] addr_q [SLOTS]
);
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic hit_alloc, hit_exec;
    assign hit_alloc = alloc_we && (int'(alloc_slot) == s);
    assign hit_exec  = exec_we  && (int'(exec_slot)  == s);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        seq_q[s]  <= '0;
        ref_q[s]  <= '0;
        aval_q[s] <= 1'b0;
        addr_q[s] <= '0;
      end else if (hit_alloc) begin
        seq_q[s]  <= alloc_seq;
        ref_q[s]  <= alloc_ref;
        aval_q[s] <= 1'b0;
      end else if (hit_exec) begin
        addr_q[s] <= exec_addr;
        aval_q[s] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lq_order_scan.sv
module lq_order_scan
  import lq_pkg::*;
#(
  parameter int SLOTS     = 5,
  parameter int IDX_W     = 3,
  parameter int ADDR_W    = 32,
  parameter int BLK_SHIFT = 8
) (
  input  logic [IDX_W-1:0]  start,
  input  logic [IDX_W-1:0]  tail,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              aval [SLOTS],
  input  logic [ADDR_W-1:0] addr [SLOTS],
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx
);
  int unsigned span;
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    span    = ring_sub(int'(tail), int'(start), SLOTS);
    // descending walk so the oldest match in the window is kept last
    for (int k = SLOTS - 1; k >= 0; k--) begin
      int unsigned ix;
      ix = ring_add(int'(start), k, SLOTS);
      if (k < int'(span) && aval[ix] &&
          ((addr[ix] >> BLK_SHIFT) == (st_addr >> BLK_SHIFT))) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(ix);
      end
    end
  end
endmodule

// File: rtl/lq_retire_calc.sv
module lq_retire_calc
  import lq_pkg::*;
#(
  parameter int SLOTS = 5,
  parameter int DEPTH = 4,
  parameter int IDX_W = 3,
  parameter int CNT_W = 3,
  parameter int SEQ_W = 16
) (
  input  logic [IDX_W-1:0] head,
  input  logic [IDX_W-1:0] tail,
  input  logic [CNT_W-1:0] cnt,
  input  logic [SEQ_W-1:0] commit_seq,
  input  logic [SEQ_W-1:0] squash_seq,
  input  logic [SEQ_W-1:0] seq [SLOTS],
  output logic [CNT_W-1:0] n_commit,
  output logic [CNT_W-1:0] n_squash
);
  always_comb begin
    logic stop_c, stop_s;
    n_commit = '0;
    n_squash = '0;
    stop_c   = 1'b0;
    stop_s   = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      int unsigned ic, is;
      ic = ring_add(int'(head), k, SLOTS);
      is = ring_sub(int'(tail), k + 1, SLOTS);
      if (!stop_c && k < int'(cnt) && seq[ic] <= commit_seq) n_commit = n_commit + 1'b1;
      else stop_c = 1'b1;
      if (!stop_s && k < int'(cnt) && seq[is] > squash_seq) n_squash = n_squash + 1'b1;
      else stop_s = 1'b1;
    end
  end
endmodule

// File: rtl/load_queue_ordchk.sv
module load_queue_ordchk
  import lq_pkg::*;
#(
  parameter int DEPTH     = 4,
  parameter int SEQ_W     = 16,
  parameter int ADDR_W    = 32,
  parameter int SQ_W      = 3,
  parameter int BLK_SHIFT = 8,
  localparam int SLOTS    = DEPTH + 1,
  localparam int IDX_W    = $clog2(SLOTS),
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int REF_W    = SQ_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [SEQ_W-1:0]  alloc_seq,
  input  logic [SQ_W-1:0]   alloc_sq_tail,
  input  logic              alloc_sq_empty,
  output logic [IDX_W-1:0]  alloc_idx,
  output logic              alloc_err,
  input  logic              exec_valid,
  input  logic [IDX_W-1:0]  exec_idx,
  input  logic [ADDR_W-1:0] exec_addr,
  input  logic              chk_valid,
  input  logic [IDX_W-1:0]  chk_lq_idx,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              chk_fault,
  input  logic              commit_valid,
  input  logic [SEQ_W-1:0]  commit_seq,
  input  logic              squash_valid,
  input  logic [SEQ_W-1:0]  squash_seq,
  input  logic              viol_rd,
  output logic              viol_valid,
  output logic [IDX_W-1:0]  viol_idx,
  output logic [SEQ_W-1:0]  viol_seq,
  output logic [REF_W-1:0]  viol_sq_ref,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty
);
  logic [IDX_W-1:0] head_q, tail_q, head_d, tail_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, n_cm, n_sq, n_cm_eff;
  logic             pend_q, err_q;
  logic [IDX_W-1:0] vidx_q;
  logic [SEQ_W-1:0] vseq_q;
  logic [REF_W-1:0] vref_q;

  logic [SEQ_W-1:0]  seq_a  [SLOTS];
  logic [REF_W-1:0]  ref_a  [SLOTS];
  logic              aval_a [SLOTS];
  logic [ADDR_W-1:0] addr_a [SLOTS];

  // named internal events
  logic do_alloc, do_exec, scan_hit, viol_capture, exec_occupied;
  logic [IDX_W-1:0] scan_idx;
  logic [REF_W-1:0] new_ref;

  assign full          = (int'(cnt_q) == DEPTH);
  assign empty         = (cnt_q == '0);
  assign do_alloc      = alloc_valid && !full && !squash_valid;
  assign exec_occupied = ring_sub(int'(exec_idx), int'(head_q), SLOTS) < int'(cnt_q);
  assign do_exec       = exec_valid && exec_occupied;
  assign new_ref       = alloc_sq_empty ? {REF_W{1'b1}} : {1'b0, alloc_sq_tail};
  assign viol_capture  = chk_valid && !pend_q && scan_hit;

  lq_entry_store #(.SLOTS(SLOTS), .IDX_W(IDX_W), .SEQ_W(SEQ_W), .REF_W(REF_W), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .alloc_we(do_alloc), .alloc_slot(tail_q), .alloc_seq(alloc_seq), .alloc_ref(new_ref),
    .exec_we(do_exec), .exec_slot(exec_idx), .exec_addr(exec_addr),
    .seq_q(seq_a), .ref_q(ref_a), .aval_q(aval_a), .addr_q(addr_a)
  );

  lq_order_scan #(.SLOTS(SLOTS), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT)) u_scan (
    .start(chk_lq_idx), .tail(tail_q), .st_addr(chk_addr),
    .aval(aval_a), .addr(addr_a), .hit(scan_hit), .hit_idx(scan_idx)
  );

  lq_retire_calc #(.SLOTS(SLOTS), .DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W), .SEQ_W(SEQ_W)) u_ret (
    .head(head_q), .tail(tail_q), .cnt(cnt_q),
    .commit_seq(commit_seq), .squash_seq(squash_seq), .seq(seq_a),
    .n_commit(n_cm), .n_squash(n_sq)
  );

  assign n_cm_eff = commit_valid ? n_cm : '0;

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    if (squash_valid) begin
      tail_d = IDX_W'(ring_sub(int'(tail_q), int'(n_sq), SLOTS));
      cnt_d  = cnt_q - n_sq;
    end else begin
      head_d = IDX_W'(ring_add(int'(head_q), int'(n_cm_eff), SLOTS));
      tail_d = do_alloc ? IDX_W'(ring_add(int'(tail_q), 1, SLOTS)) : tail_q;
      cnt_d  = cnt_q - n_cm_eff + CNT_W'(do_alloc);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      err_q  <= 1'b0;
      pend_q <= 1'b0;
      vidx_q <= '0;
      vseq_q <= '0;
      vref_q <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
      err_q  <= alloc_valid && full;
      if (viol_capture) begin
        pend_q <= 1'b1;
        vidx_q <= scan_idx;
        vseq_q <= seq_a[scan_idx];
        vref_q <= ref_a[scan_idx];
      end else if (viol_rd) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign alloc_idx   = tail_q;
  assign alloc_err   = err_q;
  assign chk_fault   = viol_capture;
  assign viol_valid  = pend_q;
  assign viol_idx    = vidx_q;
  assign viol_seq    = vseq_q;
  assign viol_sq_ref = vref_q;
  assign count       = cnt_q;

  // R11: occupancy never exceeds the usable depth
  p_cnt_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= DEPTH);
  // R2: full coincides with the sentinel condition on the pointers
  p_full_sentinel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    full == (ring_add(int'(tail_q), 1, SLOTS) == int'(head_q)));
  // R2: allocation while full leaves the tail alone
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid && full && !squash_valid |=> $stable(tail_q));
  // R5: a hit lies strictly inside the search window
  p_hit_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && scan_hit |->
      ring_sub(int'(scan_idx), int'(chk_lq_idx), SLOTS) < ring_sub(int'(tail_q), int'(chk_lq_idx), SLOTS));
  // R7: a fault leaves a pending violator
  p_fault_pends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chk_fault |=> viol_valid);
  // R8: a pending violator holds until read
  p_pend_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid && !viol_rd |=> viol_valid && $stable(viol_idx) && $stable(viol_seq));
  // R10: squash never moves the head
  p_squash_head_r10: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |=> $stable(head_q));
endmodule

// File: tb/tb_load_queue_ordchk.sv
`timescale 1ns/100ps
module tb_load_queue_ordchk;
  localparam int D = 4, S = 5;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic alloc_valid = 0, alloc_sq_empty = 0, exec_valid = 0, chk_valid = 0;
  logic commit_valid = 0, squash_valid = 0, viol_rd = 0;
  logic [15:0] alloc_seq = 0, commit_seq = 0, squash_seq = 0;
  logic [2:0]  alloc_sq_tail = 0, exec_idx = 0, chk_lq_idx = 0;
  logic [31:0] exec_addr = 0, chk_addr = 0;
  logic [2:0]  alloc_idx, viol_idx, count;
  logic [15:0] viol_seq;
  logic [3:0]  viol_sq_ref;
  logic alloc_err, chk_fault, viol_valid, full, empty;

  load_queue_ordchk dut (.*);

  int checks = 0, errors = 0;
  // bench model
  int m_seq[S], m_ref[S], m_addr[S];
  bit m_av[S];
  int m_head = 0, m_tail = 0, m_cnt = 0;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_alloc(int seq, int sqt, bit sqe);
    bit was_full;
    check("R2 alloc_idx", alloc_idx, m_tail);
    was_full = (m_cnt == D);
    alloc_valid = 1; alloc_seq = 16'(seq); alloc_sq_tail = 3'(sqt); alloc_sq_empty = sqe;
    tick(); alloc_valid = 0;
    if (!was_full) begin
      m_seq[m_tail] = seq; m_ref[m_tail] = sqe ? 15 : sqt; m_av[m_tail] = 0;
      m_tail = (m_tail + 1) % S; m_cnt++;
    end
    check("R2 alloc_err", alloc_err, was_full);
    check("R11 count", count, m_cnt);
    check("R2 full", full, m_cnt == D);
  endtask

  task automatic do_exec(int idx, int addr);
    exec_valid = 1; exec_idx = 3'(idx); exec_addr = addr;
    tick(); exec_valid = 0;
    m_addr[idx] = addr; m_av[idx] = 1;
  endtask

  task automatic do_commit(int c);
    commit_valid = 1; commit_seq = 16'(c);
    tick(); commit_valid = 0;
    while (m_cnt > 0 && m_seq[m_head] <= c) begin m_head = (m_head + 1) % S; m_cnt--; end
    check("R9 count after commit", count, m_cnt);
  endtask

  task automatic do_squash(int s, bit with_other);
    squash_valid = 1; squash_seq = 16'(s);
    commit_valid = with_other; commit_seq = 16'hFFFF;
    alloc_valid = with_other; alloc_seq = 16'd99;
    tick(); squash_valid = 0; commit_valid = 0; alloc_valid = 0;
    while (m_cnt > 0 && m_seq[(m_tail + S - 1) % S] > s) begin m_tail = (m_tail + S - 1) % S; m_cnt--; end
    check("R10 count after squash", count, m_cnt);
    check("R10 tail after squash", alloc_idx, m_tail);
    check("R11 empty", empty, m_cnt == 0);
  endtask

  // expected first match in [start, tail) on 256-byte blocks
  function automatic int exp_hit(int start, int a);
    int ix = start;
    while (ix != m_tail) begin
      if (m_av[ix] && (m_addr[ix] >>> 8) == (a >>> 8)) return ix;
      ix = (ix + 1) % S;
    end
    return -1;
  endfunction

  task automatic do_read();
    viol_rd = 1; tick(); viol_rd = 0;
    check("R8 cleared by read", viol_valid, 0);
  endtask

  task automatic do_check(int start, int a, bit pending);
    int h = pending ? -1 : exp_hit(start, a);
    chk_valid = 1; chk_lq_idx = 3'(start); chk_addr = a;
    #1;
    check("R5 R6 R7 fault", chk_fault, h >= 0);
    tick(); chk_valid = 0;
    if (h >= 0) begin
      check("R7 viol_valid", viol_valid, 1);
      check("R7 viol_idx", viol_idx, h);
      check("R7 viol_seq", viol_seq, m_seq[h]);
      check("R3 viol_sq_ref", viol_sq_ref, m_ref[h]);
      do_read();
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int addrs[6] = '{32'h1200, 32'h12FF, 32'h2000, 32'h20FF, 32'h3000, 32'h2100};
    tick(); tick(); rst_n = 1; tick();
    // R1 reset state
    check("R1 count", count, 0);
    check("R1 empty", empty, 1);
    check("R1 full", full, 0);
    check("R1 viol_valid", viol_valid, 0);
    check("R1 alloc_idx", alloc_idx, 0);
    // R2 R3 fill and overflow
    do_alloc(10, 1, 0);
    do_alloc(11, 2, 1);
    do_alloc(12, 3, 0);
    do_alloc(13, 4, 1);
    do_alloc(50, 5, 0);
    do_exec(0, 32'h3000);
    // R9 partial commit stops at a younger head
    do_commit(11);
    // R4 slot 0 reused after wrap, must lose its executed flag
    do_alloc(14, 6, 0);
    do_alloc(15, 7, 0);
    do_exec(2, 32'h1234);
    do_exec(3, 32'h2010);
    do_exec(4, 32'h2080);
    // R5 R6 R7 sweep over every start in [head, tail]
    for (int o = 0; o <= D; o++)
      foreach (addrs[i]) do_check((m_head + o) % S, addrs[i], 0);
    // R8 pending blocks a second search
    do_check(2, 32'h1200, 1'b0 == 1'b1);
    chk_valid = 1; chk_lq_idx = 3'd2; chk_addr = 32'h1200;
    tick(); chk_valid = 0;
    check("R8 pending set", viol_valid, 1);
    chk_valid = 1; chk_lq_idx = 3'd3; chk_addr = 32'h2000;
    #1 check("R8 no fault while pending", chk_fault, 0);
    tick(); chk_valid = 0;
    check("R8 violator kept", viol_idx, 2);
    do_read();
    // R10 squash with commit and alloc in the same cycle
    do_squash(13, 1);
    do_commit(12);
    do_squash(0, 0);
    // R11 reuse after empty
    do_alloc(20, 0, 1);
    check("R11 count final", count, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule